// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives a serial-interface clock from a fixed reference clock. The division ratio is the product of a linear term (m+1), with m from 0 to 15, and a power-of-two term 2^n, with n from 0 to 3. The whole ratio therefore runs from 1 to 128 reference cycles. Both terms and an enable bit come from one 32-bit configuration word. The divider gives two outputs. `sclk` is a clock level. `sclk_tick` is a one-cycle enable that marks the first reference cycle of every output period, which lets a downstream shifter stay on the reference clock even when the ratio is 1. The configuration the divider is running is visible on the read-back pins.

A mapping path sits beside the divider. It takes a requested serial rate in Hz and limits it to a maximum rate set by a parameter. It divides the reference rate by the limited rate to get a requested factor. From that factor it picks n using fixed thresholds and picks m by clamping. The chosen fields are presented on their own and also packed into a ready-to-use configuration word. Software or a sequencer can copy that word into `cfg_word`. All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `sclk_div_gen`

## Requirements
- R1: While enabled with a steady configuration, `sclk_tick` is 1 in exactly one reference cycle out of every P = (m+1)·2^n cycles.
- R2: Within each output period, the first cycle is the one that carries the tick. `sclk` is 1 for the first floor(P/2) cycles of the period and 0 for the remaining cycles.
- R3: The configuration word is decoded as m = bits 3:0, n = bits 17:16 and enable = bit 31. All other bits have no effect on any output.
- R4: While the running enable is 0, `sclk` and `sclk_tick` are 0 and `act_en` reads 0. Reset leaves the block in this state.
- R5: A new configuration word is adopted in the cycle after the last cycle of the current output period. While the block is idle it is adopted on the next clock edge. `act_en`, `act_m` and `act_n` show the adopted values from that cycle on.
- R6: The first cycle after enable is adopted carries a tick, and the period restarts from its first cycle.
- R7: With m = 0 and n = 0 enabled, `sclk_tick` is 1 in every cycle and `sclk` stays 0.
- R8: The mapped n is 3 for a requested factor above 64, 2 for a factor above 32, 1 for a factor above 16, and 0 otherwise.
- R9: The mapped m is clamp(factor >> n, 1, 16) − 1.
- R10: A requested rate above MAX_HZ is treated as MAX_HZ. A requested rate of 0 is treated as the slowest setting. The factor is REF_HZ divided by the limited rate, with integer truncation.
- R11: `map_word` carries the mapped m in bits 3:0, the mapped n in bits 17:16 and a 1 in bit 31. All its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Configuration word: m, n and enable |
| req_hz | input | RATE_W | Requested serial rate for the mapping path |
| sclk | output | 1 | Divided clock level, idle low |
| sclk_tick | output | 1 | One-cycle pulse at the start of each output period |
| act_en | output | 1 | Enable bit currently running |
| act_m | output | 4 | Linear field currently running |
| act_n | output | 2 | Exponent field currently running |
| map_m | output | 4 | Linear field chosen from `req_hz` |
| map_n | output | 2 | Exponent field chosen from `req_hz` |
| map_word | output | 32 | Chosen fields packed as a configuration word with enable set |

## Verification
The interesting collision is a write to `cfg_word` that arrives while a period is still running. The period end and the adoption of the new word can fall in the same cycle as the first tick of the following period. The bench changes the word at random points inside periods of random length, including changes that turn the enable off. It also switches between the unit ratio and long ratios, so adoption happens both at every edge and at the end of 128-cycle periods. A phase-counting model in the bench predicts the exact cycle of adoption. Every cycle it compares the tick, the clock level and the read-back fields against that model, so a configuration adopted early or late shows up as a mismatch.

// File: rtl/sclk_div_pkg.sv
`timescale 1ns/1ps
package sclk_div_pkg;
  localparam int CFG_W  = 32;
  localparam int M_W    = 4;
  localparam int M_LSB  = 0;
  localparam int N_W    = 2;
  localparam int N_LSB  = 16;
  localparam int EN_BIT = 31;

  typedef struct packed {
    logic           en;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } div_cfg_t;

  function automatic div_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    div_cfg_t c;
    c.en = w[EN_BIT];
    c.n  = w[N_LSB +: N_W];
    c.m  = w[M_LSB +: M_W];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] pack_cfg(input div_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[EN_BIT]        = c.en;
    w[N_LSB +: N_W]  = c.n;
    w[M_LSB +: M_W]  = c.m;
    return w;
  endfunction
endpackage

// File: rtl/sclk_rate_mapper.sv
`timescale 1ns/1ps
module sclk_rate_mapper #(
  parameter int unsigned REF_HZ = 24000000,
  parameter int unsigned MAX_HZ = REF_HZ,
  parameter int          RATE_W = 32,
  parameter int          M_W    = 4,
  parameter int          N_W    = 2
) (
  input  logic [RATE_W-1:0] req_hz,
  output logic [RATE_W-1:0] factor,
  output logic [M_W-1:0]    map_m,
  output logic [N_W-1:0]    map_n
);
  localparam logic [RATE_W-1:0] REF_V   = RATE_W'(REF_HZ);
  localparam logic [RATE_W-1:0] MAX_V   = RATE_W'(MAX_HZ);
  localparam logic [RATE_W-1:0] LIN_MAX = RATE_W'(1) << M_W;
  localparam int                N_MAX   = (1 << N_W) - 1;

  logic [RATE_W-1:0] lim;
  logic [RATE_W-1:0] lin;

  // limit the request, then turn it into a whole divide factor
  always_comb begin
    lim    = (req_hz > MAX_V) ? MAX_V : req_hz;
    factor = (lim == '0) ? REF_V : REF_V / lim;
  end

  // exponent: thresholds double from the linear stage's full range
  always_comb begin
    map_n = '0;
    for (int k = 1; k <= N_MAX; k++) begin
      if (factor > (LIN_MAX << (k - 1))) map_n = N_W'(k);
    end
  end

  // linear stage: what remains after the power-of-two stage, clamped
  always_comb begin
    lin = factor >> map_n;
    if (lin > LIN_MAX) lin = LIN_MAX;
    if (lin == '0)     lin = RATE_W'(1);
    map_m = M_W'(lin - RATE_W'(1));
  end
endmodule

// File: rtl/sclk_cfg_shadow.sv
`timescale 1ns/1ps
module sclk_cfg_shadow
  import sclk_div_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  div_cfg_t cfg_in,
  input  logic     adopt,
  output div_cfg_t act
);
  // running configuration; only replaced on a period boundary or when idle
  always_ff @(posedge clk) begin
    if (!rst_n)     act <= '0;
    else if (adopt) act <= cfg_in;
  end
endmodule

// File: rtl/sclk_div_counters.sv
`timescale 1ns/1ps
module sclk_div_counters #(
  parameter int M_W = 4,
  parameter int N_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [M_W-1:0] lin_last,
  input  logic [N_W-1:0] pow_exp,
  output logic           period_end,
  output logic           tick,
  output logic           level
);
  localparam int POW_W = (1 << N_W) - 1;

  logic [M_W-1:0]   lin_q;
  logic [POW_W-1:0] pow_q;
  logic [POW_W-1:0] pow_last;
  logic [M_W:0]     lin_half;
  logic             lin_wrap;
  logic             pow_hi;

  // last count of the power-of-two stage: 2^n - 1
  always_comb begin
    pow_last = '0;
    for (int i = 0; i < POW_W; i++) pow_last[i] = (i < int'(pow_exp));
  end

  assign lin_wrap   = (lin_q == lin_last);
  assign period_end = run && lin_wrap && (pow_q == pow_last);

  // stage one counts reference cycles; stage two counts stage-one wraps
  always_ff @(posedge clk) begin
    if (!rst_n || !run || period_end) begin
      lin_q <= '0;
      pow_q <= '0;
    end else if (lin_wrap) begin
      lin_q <= '0;
      pow_q <= pow_q + 1'b1;
    end else begin
      lin_q <= lin_q + 1'b1;
    end
  end

  // high half: top bit of stage two when n > 0, else first half of stage one
  always_comb begin
    lin_half = ({1'b0, lin_last} + 1'b1) >> 1;
    pow_hi   = 1'b0;
    for (int i = 0; i < POW_W; i++) begin
      if (i + 1 == int'(pow_exp)) pow_hi = !pow_q[i];
    end
    if (pow_exp == '0) pow_hi = ({1'b0, lin_q} < lin_half);
  end

  assign tick  = run && (lin_q == '0) && (pow_q == '0);
  assign level = run && pow_hi;
endmodule

// File: rtl/sclk_div_gen.sv
`timescale 1ns/1ps
module sclk_div_gen
  import sclk_div_pkg::*;
#(
  parameter int unsigned REF_HZ = 24000000,
  parameter int unsigned MAX_HZ = REF_HZ,
  parameter int          RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [RATE_W-1:0] req_hz,
  output logic              sclk,
  output logic              sclk_tick,
  output logic              act_en,
  output logic [M_W-1:0]    act_m,
  output logic [N_W-1:0]    act_n,
  output logic [M_W-1:0]    map_m,
  output logic [N_W-1:0]    map_n,
  output logic [CFG_W-1:0]  map_word
);
  div_cfg_t          wr_cfg;
  div_cfg_t          act;
  div_cfg_t          map_cfg;
  logic              period_end;
  logic              adopt;
  logic [RATE_W-1:0] factor;
  logic [RATE_W-1:0] map_prod;

  assign wr_cfg = unpack_cfg(cfg_word);
  assign adopt  = !act.en || period_end;

  sclk_cfg_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_in (wr_cfg),
    .adopt  (adopt),
    .act    (act)
  );

  sclk_div_counters #(.M_W(M_W), .N_W(N_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (act.en),
    .lin_last   (act.m),
    .pow_exp    (act.n),
    .period_end (period_end),
    .tick       (sclk_tick),
    .level      (sclk)
  );

  sclk_rate_mapper #(
    .REF_HZ (REF_HZ), .MAX_HZ (MAX_HZ), .RATE_W (RATE_W),
    .M_W (M_W), .N_W (N_W)
  ) u_map (
    .req_hz (req_hz),
    .factor (factor),
    .map_m  (map_m),
    .map_n  (map_n)
  );

  always_comb begin
    map_cfg.en = 1'b1;
    map_cfg.m  = map_m;
    map_cfg.n  = map_n;
    map_word   = pack_cfg(map_cfg);
    map_prod   = (RATE_W'(map_m) + RATE_W'(1)) << map_n;
  end

  assign act_en = act.en;
  assign act_m  = act.m;
  assign act_n  = act.n;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> (!sclk && !sclk_tick)); // R4
  AST_ADOPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_en, act_n, act_m}) |-> $past(!act_en || period_end)); // R5
  AST_START_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_en) |-> sclk_tick); // R6
  AST_UNIT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && act_m == '0 && act_n == '0) |-> (sclk_tick && !sclk)); // R7
  AST_MAP_NOT_FASTER: assert property (@(posedge clk) disable iff (!rst_n)
    map_prod <= factor || factor == '0); // R9
endmodule

// File: tb/tb_sclk_div_gen.sv
`timescale 1ns/1ps
module tb_sclk_div_gen;
  localparam int unsigned REF_HZ = 24000000;
  localparam int unsigned MAX_HZ = 24000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [31:0] req_hz = '0;
  logic        sclk, sclk_tick, act_en;
  logic [3:0]  act_m, map_m;
  logic [1:0]  act_n, map_n;
  logic [31:0] map_word;

  int checks = 0;
  int errors = 0;
  string tick_tag_override = "";

  sclk_div_gen #(.REF_HZ(REF_HZ), .MAX_HZ(MAX_HZ), .RATE_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req_hz(req_hz),
    .sclk(sclk), .sclk_tick(sclk_tick), .act_en(act_en), .act_m(act_m),
    .act_n(act_n), .map_m(map_m), .map_n(map_n), .map_word(map_word)
  );

  always #2 clk = ~clk;

  // phase-counting reference model
  logic men = 1'b0, prev_men = 1'b0;
  int   mm = 0, mn = 0, p = 0;
  function automatic int per(input int m, input int n);
    return (m + 1) << n;
  endfunction
  always @(posedge clk) begin
    prev_men <= men;
    if (!rst_n) begin
      men <= 1'b0; mm <= 0; mn <= 0; p <= 0;
    end else if (!men || p == per(mm, mn) - 1) begin
      men <= cfg_word[31]; mm <= int'(cfg_word[3:0]); mn <= int'(cfg_word[17:16]); p <= 0;
    end else begin
      p <= p + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge, before inputs move
  task automatic check_div();
    int P;
    int et, es;
    string tt, ts;
    P  = per(mm, mn);
    et = (men && p == 0) ? 1 : 0;
    es = (men && p < P / 2) ? 1 : 0;
    if (!men)               begin tt = "R4"; ts = "R4"; end
    else if (P == 1)        begin tt = "R7"; ts = "R7"; end
    else                    begin tt = "R1"; ts = "R2"; end
    if (men && !prev_men) tt = "R6";
    if (tick_tag_override != "") tt = tick_tag_override;
    chk({tt, " tick"}, int'(sclk_tick), et);
    chk({ts, " sclk"}, int'(sclk), es);
    chk("R5 act_en", int'(act_en), int'(men));
    if (men) begin
      chk("R5 act_m", int'(act_m), mm);
      chk("R5 act_n", int'(act_n), mn);
    end
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_div();
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int m, input int n, input bit en, input logic [31:0] junk);
    logic [31:0] w;
    w = junk & ~32'h8003_000F;
    w[3:0] = 4'(m); w[17:16] = 2'(n); w[31] = en;
    return w;
  endfunction

  // expected mapping, from the requirements
  task automatic check_map(input logic [31:0] r, input string ltag);
    longint lim, f, lin;
    int en_n, en_m;
    logic [31:0] ew;
    lim = (longint'(r) > longint'(MAX_HZ)) ? longint'(MAX_HZ) : longint'(r);
    f   = (lim == 0) ? longint'(REF_HZ) : longint'(REF_HZ) / lim;
    en_n = (f > 64) ? 3 : (f > 32) ? 2 : (f > 16) ? 1 : 0;
    lin = f >> en_n;
    if (lin > 16) lin = 16;
    if (lin < 1) lin = 1;
    en_m = int'(lin) - 1;
    ew = 32'h8000_0000 | (32'(en_n) << 16) | 32'(en_m);
    req_hz = r;
    #1;
    chk({ltag, " R8 map_n"}, int'(map_n), en_n);
    chk({ltag, " R9 map_m"}, int'(map_m), en_m);
    chk("R11 map_word", int'(map_word), int'(ew));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4217));
    // reset state (R4)
    repeat (3) @(negedge clk);
    chk("R4 reset sclk", int'(sclk), 0);
    chk("R4 reset tick", int'(sclk_tick), 0);
    chk("R4 reset act_en", int'(act_en), 0);
    rst_n = 1'b1;
    run_cycles(3);

    // R7 unit ratio, then R6 restart
    cfg_word = mk_cfg(0, 0, 1'b1, 32'h0);
    run_cycles(10);
    // R1/R2 odd and even ratios
    cfg_word = mk_cfg(2, 0, 1'b1, 32'h0); run_cycles(20);
    cfg_word = mk_cfg(4, 1, 1'b1, 32'h0); run_cycles(40);
    // longest ratio 128
    cfg_word = mk_cfg(15, 3, 1'b1, 32'h0); run_cycles(300);
    // R3 junk bits only: nothing may change
    tick_tag_override = "R3";
    cfg_word = mk_cfg(15, 3, 1'b1, 32'h7FFC_FFF0); run_cycles(200);
    tick_tag_override = "";
    // R5 change mid-period, including disable
    cfg_word = mk_cfg(1, 0, 1'b1, 32'h0); run_cycles(5);
    cfg_word = mk_cfg(3, 2, 1'b1, 32'h0); run_cycles(7);
    cfg_word = mk_cfg(3, 2, 1'b0, 32'h0); run_cycles(40);
    cfg_word = mk_cfg(0, 1, 1'b1, 32'h0); run_cycles(9);

    // random segments
    for (int s = 0; s < 80; s++) begin
      int hold;
      cfg_word = mk_cfg(int'($urandom_range(15)), int'($urandom_range(3)),
                        ($urandom_range(99) < 85), $urandom);
      hold = int'($urandom_range(1, 250));
      run_cycles(hold);
    end

    // mapping: directed thresholds and clamps
    check_map(32'd24000000, "R10");
    check_map(32'd48000000, "R10");
    check_map(32'd0,        "R10");
    check_map(32'd1500000,  "R9");
    check_map(32'd1400000,  "R8");
    check_map(32'd750000,   "R8");
    check_map(32'd700000,   "R8");
    check_map(32'd375000,   "R8");
    check_map(32'd360000,   "R8");
    check_map(32'd100000,   "R9");
    check_map(32'd1,        "R9");
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = ($urandom_range(3) == 0) ? $urandom : 32'($urandom_range(30000000));
      check_map(r, "R9");
    end
    finish_run();
  end
endmodule